// File: doc/BRIEF.md
# Unaligned Load/Store Bus Sequencer

This block sits between a processor core and a 32-bit memory bus built from four byte-wide banks. The core hands it one load or store at a time: a byte, a 16-bit word or a 32-bit double word, at any byte address. The block turns each request into one or two bus cycles. Every bus cycle carries an address that is a multiple of four and four byte-lane enables. Bytes are moved between their memory lanes and their place in the register value, little-endian. When all bytes of a request have moved, the core gets one completion pulse, together with the assembled load value for a load.

A request whose bytes span two aligned 4-byte groups is split. The first cycle covers the lower group and the second covers the next group up. When the strict input is high, a misaligned word or double word is not split: it completes at once with a fault flag and no bus cycle.

The sequencer is a four-state machine. ST_IDLE waits for a request. ST_LOW runs the first or only bus cycle. ST_HIGH runs the second cycle of a split. ST_RESP presents the completion for one cycle. The transitions are:
- accept: IDLE to LOW.
- reject: IDLE to RESP, for a strict fault.
- stall: LOW to LOW or HIGH to HIGH, while the bus is not ready.
- split: LOW to HIGH.
- finish: LOW to RESP or HIGH to RESP.
- release: RESP to IDLE.

Top module: `misalign_seq`

## Requirements
- R1: After reset, busy, done and bus_valid are all low.
- R2: Every bus address is a multiple of four. The first bus cycle of a request uses the request address with its two low bits cleared.
- R3: The byte at offset k within an aligned group travels on data bits 8k+7 down to 8k, with bus_be bit k high. Every bus cycle has at least one enable set.
- R4: A byte request (req_size 00) at any offset uses exactly one bus cycle with exactly one enable set.
- R5: A word request (req_size 01) uses one bus cycle at offsets 0, 1 and 2, and two bus cycles at offset 3.
- R6: A double-word request (req_size 10 or 11) uses one bus cycle at offset 0 and two bus cycles at any other offset.
- R7: In a split request, the second cycle's address is the first cycle's address plus four. Its enables cover only the bytes the first cycle did not.
- R8: A load returns, on rdata during the done cycle, the byte at the request address in bits 7:0 and the following bytes in rising order. Bits above the access size are zero.
- R9: A store writes exactly the enabled bytes. Byte i of req_wdata (bits 8i+7 to 8i) lands at request address plus i, and neighbouring bytes are untouched.
- R10: With strict high, a word at offset 1 or 3, or a double word at a nonzero offset, issues no bus cycle. It completes one cycle after acceptance with done and fault high. Aligned accesses under strict, and every access with strict low, complete without fault.
- R11: A bus cycle holds its address, enables and valid until bus_ready is seen. Each request produces exactly one done pulse, one cycle after its last bus handshake.
- R12: busy is high from the cycle after acceptance through the done cycle. req_valid while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strict | input | 1 | Fault misaligned words and double words instead of splitting them |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 word, 1x double word |
| req_addr | input | AW (32) | Byte address |
| req_wdata | input | 32 | Store value, least significant byte in bits 7:0 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Alignment fault, valid with done |
| rdata | output | 32 | Assembled load value, valid with done |
| bus_valid | output | 1 | Bus cycle request |
| bus_wr | output | 1 | Bus cycle is a write |
| bus_addr | output | AW (32) | Aligned bus address |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Read data from the banks |
| bus_ready | input | 1 | Memory accepts or completes the current bus cycle |

## Verification
The assertions assume that the memory side answers every bus cycle with bus_ready at some point. They also assume that bus_rdata is valid in the cycle where bus_ready is high. The bench's bank model raises ready after a set number of wait cycles and drives read data straight from its byte array at the presented address. New requests are driven only at falling edges, and a second request is offered while busy only in the scenario that checks it is ignored.

// File: rtl/misalign_pkg.sv
package misalign_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_RESP
    } seq_state_t;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;
endpackage

// File: rtl/misalign_lane_plan.sv
module misalign_lane_plan
    import misalign_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OW = $clog2(LANES)
) (
    input  logic [1:0]       size,
    input  logic [OW-1:0]    off,
    input  logic             strict,
    output logic [LANES-1:0] size_mask,
    output logic [LANES-1:0] be_lo,
    output logic [LANES-1:0] be_hi,
    output logic             split,
    output logic             align_fault
);
    logic [2*LANES-1:0] wide;

    always_comb begin
        unique case (size)
            SZ_BYTE: size_mask = LANES'(1);
            SZ_WORD: size_mask = LANES'(3);
            default: size_mask = '1;
        endcase
        wide  = {{LANES{1'b0}}, size_mask} << off;
        be_lo = wide[LANES-1:0];
        be_hi = wide[2*LANES-1:LANES];
        split = |be_hi;
        align_fault = strict &&
                      (((size == SZ_WORD) && off[0]) || (size[1] && (off != '0)));
    end
endmodule

// File: rtl/misalign_steer.sv
module misalign_steer #(
    parameter int LANES = 4,
    localparam int DW = 8 * LANES,
    localparam int OW = $clog2(LANES)
) (
    input  logic [OW-1:0]    off,
    input  logic [LANES-1:0] size_mask,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    lo_word,
    input  logic [DW-1:0]    hi_word,
    output logic [DW-1:0]    wr_lo,
    output logic [DW-1:0]    wr_hi,
    output logic [DW-1:0]    rd_out
);
    logic [2*DW-1:0] wshift;
    logic [2*DW-1:0] rshift;
    logic [OW+2:0]   amt;

    always_comb begin
        amt    = {off, 3'b000};
        wshift = {{DW{1'b0}}, wdata} << amt;
        rshift = {hi_word, lo_word} >> amt;
        wr_lo  = wshift[DW-1:0];
        wr_hi  = wshift[2*DW-1:DW];
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rd_out[8*k +: 8] = size_mask[k] ? rshift[8*k +: 8] : 8'h00;
    end
endmodule

// File: rtl/misalign_seq.sv
module misalign_seq
    import misalign_pkg::*;
#(
    parameter int AW = 32,
    parameter int LANES = 4,
    localparam int DW = 8 * LANES,
    localparam int OW = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strict,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic [DW-1:0]    rdata,
    output logic             bus_valid,
    output logic             bus_wr,
    output logic [AW-1:0]    bus_addr,
    output logic [LANES-1:0] bus_be,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_ready
);
    seq_state_t state, state_nx;

    logic [LANES-1:0] plan_mask, plan_lo, plan_hi;
    logic             plan_split, plan_fault;

    logic             lat_write, split_q, fault_q;
    logic [OW-1:0]    lat_off;
    logic [AW-OW-1:0] lat_base;
    logic [DW-1:0]    lat_wdata, lo_q, hi_q;
    logic [LANES-1:0] mask_q, be_lo_q, be_hi_q;
    logic [DW-1:0]    st_lo, st_hi, ld_val;

    logic accept;
    assign accept = (state == ST_IDLE) && req_valid;

    misalign_lane_plan #(.LANES(LANES)) plan_i (
        .size        (req_size),
        .off         (req_addr[OW-1:0]),
        .strict      (strict),
        .size_mask   (plan_mask),
        .be_lo       (plan_lo),
        .be_hi       (plan_hi),
        .split       (plan_split),
        .align_fault (plan_fault)
    );

    misalign_steer #(.LANES(LANES)) steer_i (
        .off       (lat_off),
        .size_mask (mask_q),
        .wdata     (lat_wdata),
        .lo_word   (lo_q),
        .hi_word   (hi_q),
        .wr_lo     (st_lo),
        .wr_hi     (st_hi),
        .rd_out    (ld_val)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = plan_fault ? ST_RESP : ST_LOW;
            ST_LOW:  if (bus_ready) state_nx = split_q ? ST_HIGH : ST_RESP;
            ST_HIGH: if (bus_ready) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_write <= 1'b0;
            split_q   <= 1'b0;
            fault_q   <= 1'b0;
            lat_off   <= '0;
            lat_base  <= '0;
            lat_wdata <= '0;
            mask_q    <= '0;
            be_lo_q   <= '0;
            be_hi_q   <= '0;
            lo_q      <= '0;
            hi_q      <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                lat_write <= req_write;
                split_q   <= plan_split;
                fault_q   <= plan_fault;
                lat_off   <= req_addr[OW-1:0];
                lat_base  <= req_addr[AW-1:OW];
                lat_wdata <= req_wdata;
                mask_q    <= plan_mask;
                be_lo_q   <= plan_lo;
                be_hi_q   <= plan_hi;
                lo_q      <= '0;
                hi_q      <= '0;
            end
            if (state == ST_LOW && bus_ready)  lo_q <= bus_rdata;
            if (state == ST_HIGH && bus_ready) hi_q <= bus_rdata;
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        bus_valid = (state == ST_LOW) || (state == ST_HIGH);
        bus_wr    = bus_valid && lat_write;
        bus_addr  = '0;
        bus_be    = '0;
        bus_wdata = '0;
        unique case (state)
            ST_LOW: begin
                bus_addr  = {lat_base, {OW{1'b0}}};
                bus_be    = be_lo_q;
                bus_wdata = lat_write ? st_lo : '0;
            end
            ST_HIGH: begin
                bus_addr  = {lat_base + 1'b1, {OW{1'b0}}};
                bus_be    = be_hi_q;
                bus_wdata = lat_write ? st_hi : '0;
            end
            default: ;
        endcase
        done  = (state == ST_RESP);
        fault = done && fault_q;
        rdata = (done && !lat_write && !fault_q) ? ld_val : '0;
    end

    p_lane_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_be != '0));

    p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && mask_q == LANES'(1)) |-> ($countones(bus_be) == 1));

    p_split_next_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && $past(state) == ST_LOW) |->
        (bus_addr == $past(bus_addr) + AW'(LANES)));

    p_fault_no_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> ($past(state) == ST_IDLE));

    p_hold_until_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=>
        (bus_valid && $stable(bus_addr) && $stable(bus_be)));

    p_single_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/misalign_seq_tb_top.sv
`timescale 1ns/1ps
module misalign_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strict = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, fault, bus_valid, bus_wr, bus_ready;
    logic [31:0] rdata, bus_addr, bus_wdata, bus_rdata;
    logic [3:0]  bus_be;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  mem [256];
    int          wait_cfg = 0;
    int          wcnt = 0;
    int          hs_total = 0;
    int          hs_base = 0;
    logic [31:0] a_first, a_second;
    logic [3:0]  be_first, be_second;

    always #4 clk = ~clk;

    misalign_seq dut_i (
        .clk(clk), .rst_n(rst_n), .strict(strict),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .fault(fault), .rdata(rdata),
        .bus_valid(bus_valid), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready)
    );

    assign bus_ready = bus_valid && (wcnt == wait_cfg);

    always_comb begin
        for (int k = 0; k < 4; k++)
            bus_rdata[8*k +: 8] = mem[8'(bus_addr[7:0] + k)];
    end

    always @(posedge clk) begin
        if (bus_valid && !bus_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (bus_valid && bus_ready) begin
            if (hs_total == hs_base) begin
                a_first <= bus_addr; be_first <= bus_be;
            end else begin
                a_second <= bus_addr; be_second <= bus_be;
            end
            hs_total <= hs_total + 1;
            if (bus_wr)
                for (int k = 0; k < 4; k++)
                    if (bus_be[k]) mem[8'(bus_addr[7:0] + k)] <= bus_wdata[8*k +: 8];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, input logic st,
                          output logic [31:0] rd, output logic flt, output int lat,
                          output int cyc);
        @(negedge clk);
        hs_base = hs_total;
        strict = st; req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        rd = rdata; flt = fault; cyc = hs_total - hs_base;
    endtask

    task automatic t_check(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                           input logic [31:0] wd, input string tag);
        logic [31:0] rd, exp, ebe;
        logic        flt;
        int          lat, cyc, n, off, ecyc;
        logic [7:0]  below, above;
        n = nbytes(sz); off = int'(a[1:0]);
        ecyc = (off + n > 4) ? 2 : 1;
        exp = '0;
        for (int i = 0; i < n; i++) exp[8*i +: 8] = mem[8'(a[7:0] + i)];
        below = mem[8'(a[7:0] - 1)];
        above = mem[8'(a[7:0] + n)];
        ebe = ((32'(1) << n) - 1) << off;
        access(wr, sz, a, wd, 1'b0, rd, flt, lat, cyc);
        chk(cyc == ecyc, {tag, " bus cycle count"}, cyc, ecyc);
        chk(flt == 1'b0, {tag, " R10 no fault when not strict"}, flt, 0);
        chk(lat == ecyc * (wait_cfg + 1) + 1, {tag, " R11 done latency"}, lat,
            ecyc * (wait_cfg + 1) + 1);
        chk(a_first == {a[31:2], 2'b00}, {tag, " R2 first address"}, a_first,
            {a[31:2], 2'b00});
        chk(be_first == ebe[3:0], {tag, " R3 first enables"}, be_first, ebe[3:0]);
        if (ecyc == 2) begin
            chk(a_second == {a[31:2], 2'b00} + 4, {tag, " R7 second address"},
                a_second, {a[31:2], 2'b00} + 4);
            chk(be_second == ebe[7:4], {tag, " R7 second enables"}, be_second, ebe[7:4]);
        end
        if (!wr) begin
            chk(rd == exp, {tag, " R8 load value"}, rd, exp);
        end else begin
            for (int i = 0; i < n; i++)
                chk(mem[8'(a[7:0] + i)] == wd[8*i +: 8], {tag, " R9 stored byte"},
                    32'(mem[8'(a[7:0] + i)]), 32'(wd[8*i +: 8]));
            chk(mem[8'(a[7:0] - 1)] == below, {tag, " R9 byte below untouched"},
                32'(mem[8'(a[7:0] - 1)]), 32'(below));
            chk(mem[8'(a[7:0] + n)] == above, {tag, " R9 byte above untouched"},
                32'(mem[8'(a[7:0] + n)]), 32'(above));
        end
    endtask

    task automatic t_reset;
        chk(busy == 0 && done == 0 && bus_valid == 0, "R1 reset outputs",
            {29'b0, busy, done, bus_valid}, 0);
    endtask

    task automatic t_bytes;
        for (int o = 0; o < 4; o++) begin
            t_check(1'b1, 2'b00, 32'h40 + o, 32'hA0 + o, "R4 byte store");
            t_check(1'b0, 2'b00, 32'h40 + o, 0, "R4 byte load");
        end
    endtask

    task automatic t_words;
        for (int o = 0; o < 4; o++) begin
            t_check(1'b1, 2'b01, 32'h50 + o, 32'hBEEF0000 + 32'(o * 17), "R5 word store");
            t_check(1'b0, 2'b01, 32'h60 + o, 0, "R5 word load");
        end
    endtask

    task automatic t_dwords;
        for (int o = 0; o < 4; o++) begin
            t_check(1'b1, 2'b10, 32'h70 + 8 * o + o, 32'h11223344 + 32'(o), "R6 dword store");
            t_check(1'b0, 2'b11, 32'h90 + o, 0, "R6 dword load");
        end
    endtask

    task automatic t_waits;
        wait_cfg = 2;
        t_check(1'b0, 2'b10, 32'hA2, 0, "R11 stalled dword load");
        t_check(1'b1, 2'b01, 32'hB3, 32'h0000C3D4, "R11 stalled word store");
        wait_cfg = 0;
    endtask

    task automatic t_strict;
        logic [31:0] rd;
        logic        flt;
        int          lat, cyc;
        access(1'b0, 2'b01, 32'hC1, 0, 1'b1, rd, flt, lat, cyc);
        chk(flt == 1 && cyc == 0 && lat == 1, "R10 strict odd word faults",
            {flt, 7'b0, 8'(cyc), 16'(lat)}, {1'b1, 7'b0, 8'd0, 16'd1});
        access(1'b1, 2'b10, 32'hC6, 32'hFFFFFFFF, 1'b1, rd, flt, lat, cyc);
        chk(flt == 1 && cyc == 0 && lat == 1, "R10 strict dword faults",
            {flt, 7'b0, 8'(cyc), 16'(lat)}, {1'b1, 7'b0, 8'd0, 16'd1});
        chk(mem[8'hC6] != 8'hFF, "R10 faulted store left memory", 32'(mem[8'hC6]), 0);
        access(1'b0, 2'b01, 32'hC2, 0, 1'b1, rd, flt, lat, cyc);
        chk(flt == 0 && cyc == 1, "R10 strict even word ok", {flt, 23'b0, 8'(cyc)}, 1);
        access(1'b0, 2'b00, 32'hC3, 0, 1'b1, rd, flt, lat, cyc);
        chk(flt == 0 && cyc == 1, "R10 strict byte ok", {flt, 23'b0, 8'(cyc)}, 1);
        strict = 1'b0;
    endtask

    task automatic t_busy;
        logic [31:0] guard;
        int          lat, base;
        guard = {mem[8'hE3], mem[8'hE2], mem[8'hE1], mem[8'hE0]};
        @(negedge clk);
        base = hs_total; hs_base = hs_total;
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'b10;
        req_addr = 32'hD1; req_wdata = 32'h5A5A5A5A;
        @(negedge clk);
        chk(busy == 1, "R12 busy after accept", busy, 1);
        req_addr = 32'hE0; req_wdata = 32'h0BADF00D;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk(busy == 1, "R12 busy in done cycle", busy, 1);
        req_valid = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R12 idle after done", busy, 0);
        chk(hs_total - base == 2, "R12 only first request ran", hs_total - base, 2);
        chk({mem[8'hE3], mem[8'hE2], mem[8'hE1], mem[8'hE0]} == guard,
            "R12 ignored store left memory",
            {mem[8'hE3], mem[8'hE2], mem[8'hE1], mem[8'hE0]}, guard);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        #1;
        t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_bytes;
        t_words;
        t_dwords;
        t_waits;
        t_strict;
        t_busy;
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule